// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave side of a three-wire serial link: a load strobe that frames each transfer, a serial clock, and one data line. The data line is carried as separate input, output and output-enable signals for a pad. Behind the link sits a bank of four control words of unequal width. A host writes one word, or a run of adjacent words in a single frame, and can read any word back. Every port input passes through a synchronizer and is handled in the block's own clock domain, so the serial clock must run well below the system clock.

Written bits collect in shadow storage. The committed words, which drive the output ports, change only when the load strobe returns high. All words that were fully shifted in that frame then change together. A counter blocks all writes for a set number of clocks after reset. Writing 1 to bit 4 of word 0 puts every word back to its reset value.

Top module: `sreg_port`

## Requirements
- R1: While the load strobe is low, the data line is sampled on each rising serial-clock edge. A frame carries a direction bit (0 = write, 1 = read), then a 3-bit address sent least significant bit first, then one ignored test bit, then data sent least significant bit first.
- R2: Address 0 selects an 11-bit word, 1 a 10-bit word, 2 an 8-bit word and 3 a 10-bit word. Writes to addresses 4 to 7 change nothing, and reads of them return zeros.
- R3: In a write frame, data for the next address follows directly after the last bit of the previous word. Each word takes exactly its own width, and the address steps up by one after each word.
- R4: Committed words stay unchanged while a frame is in progress. They change three system clocks after the load strobe rises at the port, and every fully shifted word changes in the same cycle.
- R5: If the load strobe rises before all bits of a word have arrived, that word keeps its old value. The complete words before it still commit.
- R6: In a read frame, the output enable rises after the fifth falling serial-clock edge and drives bit 0 of the selected word. Each later falling edge drives the next bit, and bits past the word's width read 0. Outside this phase the enable is low, and it drops when the strobe rises.
- R7: A committed write of word 0 with bit 4 set returns all four words to their reset values, including word 0 itself.
- R8: After reset the words hold 0x000, 0x000, 0x080 and 0x000 for addresses 0 to 3, and the output enable is low.
- R9: During the first LOCK_CYCLES system clocks after reset, write frames commit nothing.
- R10: Serial-clock edges while the load strobe is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_load | input | 1 | Frame strobe, low during a transfer |
| ser_clk | input | 1 | Serial clock |
| ser_din | input | 1 | Serial data from the pad |
| ser_dout | output | 1 | Serial read data to the pad |
| ser_dout_en | output | 1 | Pad driver enable for read data |
| op_word | output | 11 | Committed word at address 0 |
| gain_word | output | 10 | Committed word at address 1 |
| clamp_word | output | 8 | Committed word at address 2 |
| ctrl_word | output | 10 | Committed word at address 3 |

## Verification
The assertions check on every cycle the rules that hold in any state. Once the lockout ends, it never comes back. Committed words hold still in every cycle without a commit and in every cycle of the lockout. A software reset always lands on the reset values. The pad driver is enabled only in read frames and drops once the strobe rises. Only the bench's scenarios can show the bit ordering, the address stepping through words of unequal width, discarding a partial word, and the serial timing of readback. It checks these with a behavioural model compared on every clock and with literal expected words.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    localparam int NREG      = 4;
    localparam int ADDR_W    = 3;
    localparam int WORD_W    = 11;
    localparam int IDX_W     = $clog2(WORD_W + 1);
    localparam int HDR_BITS  = 5;
    localparam int SWRST_BIT = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [NREG-1:0][WORD_W-1:0] bank_t;

    // bit length of each word; the auto-increment walk depends on it
    function automatic int unsigned reg_len(input logic [1:0] idx);
        case (idx)
            2'd0:    return 11;
            2'd1:    return 10;
            2'd2:    return 8;
            default: return 10;
        endcase
    endfunction

    function automatic word_t len_mask(input int idx);
        return word_t'((32'd1 << reg_len(2'(idx))) - 32'd1);
    endfunction

    function automatic bank_t bank_defaults();
        bank_t b;
        for (int i = 0; i < NREG; i++) b[i] = (i == 2) ? word_t'(11'h080) : '0;
        return b;
    endfunction
endpackage

// File: rtl/sreg_sync_edge.sv
module sreg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic sl_i,
    input  logic sdi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic sl_rise,
    output logic sl_fall,
    output logic sl_low,
    output logic sdi_s
);
    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] sl;
        logic [STAGES-1:0] sdi;
        logic              sck_last;
        logic              sl_last;
    } sync_t;

    sync_t state_d, state_q;
    logic  sck_s, sl_s;

    assign sck_s = state_q.sck[STAGES-1];
    assign sl_s  = state_q.sl[STAGES-1];

    always_comb begin
        state_d          = state_q;
        state_d.sck      = {state_q.sck[STAGES-2:0], sck_i};
        state_d.sl       = {state_q.sl[STAGES-2:0], sl_i};
        state_d.sdi      = {state_q.sdi[STAGES-2:0], sdi_i};
        state_d.sck_last = sck_s;
        state_d.sl_last  = sl_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{sck: '0, sl: '1, sdi: '0, sck_last: 1'b0, sl_last: 1'b1};
        end else begin
            state_q <= state_d;
        end
    end

    assign sck_rise = sck_s & ~state_q.sck_last;
    assign sck_fall = ~sck_s & state_q.sck_last;
    assign sl_rise  = sl_s & ~state_q.sl_last;
    assign sl_fall  = ~sl_s & state_q.sl_last;
    assign sl_low   = ~sl_s;
    assign sdi_s    = state_q.sdi[STAGES-1];
endmodule

// File: rtl/sreg_lockout.sv
module sreg_lockout #(
    parameter int CYCLES = 40000
) (
    input  logic clk,
    input  logic rst_n,
    output logic locked
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign locked = (cnt_q < CNT_W'(CYCLES));

    always_comb begin
        cnt_d = cnt_q;
        if (locked) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // once released, writes stay enabled until the next reset
    assert_lock_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> !locked);
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame import sreg_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_rise,
    input  logic             sck_fall,
    input  logic             sl_rise,
    input  logic             sl_fall,
    input  logic             sl_low,
    input  logic             sdi,
    input  bank_t            rd_bank,
    output logic             commit,
    output logic [NREG-1:0]  load_mask,
    output bank_t            shadow,
    output logic             dout,
    output logic             dout_en
);
    localparam logic [2:0] HDR_DATA  = 3'(HDR_BITS);
    localparam logic [2:0] FALL_LAST = 3'(HDR_BITS - 1);

    typedef struct packed {
        logic [2:0]        hdr;
        logic              rnw;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  sub;
        logic [NREG-1:0]   loaded;
        bank_t             shadow;
        logic [2:0]        falls;
        logic [IDX_W-1:0]  rd_idx;
        logic              dout;
        logic              oe;
    } frame_t;

    frame_t           state_d, state_q;
    word_t            rd_word;
    logic [IDX_W-1:0] nxt_idx;
    logic             addr_ok;

    assign addr_ok = (state_q.addr < ADDR_W'(NREG));
    assign rd_word = addr_ok ? rd_bank[state_q.addr[1:0]] : '0;

    always_comb begin
        state_d = state_q;
        nxt_idx = state_q.rd_idx;
        if (sl_fall) begin
            state_d.hdr    = '0;
            state_d.rnw    = 1'b0;
            state_d.addr   = '0;
            state_d.sub    = '0;
            state_d.loaded = '0;
            state_d.falls  = '0;
            state_d.rd_idx = '0;
            state_d.oe     = 1'b0;
        end else if (sl_rise) begin
            state_d.oe = 1'b0;
        end else if (sl_low) begin
            if (sck_rise) begin
                if (state_q.hdr == 3'd0) begin
                    state_d.rnw = sdi;
                    state_d.hdr = 3'd1;
                end else if (state_q.hdr < 3'd4) begin
                    state_d.addr[state_q.hdr[1:0] - 2'd1] = sdi;
                    state_d.hdr = state_q.hdr + 3'd1;
                end else if (state_q.hdr == 3'd4) begin
                    state_d.hdr = HDR_DATA;
                end else if (!state_q.rnw && addr_ok) begin
                    state_d.shadow[state_q.addr[1:0]][state_q.sub] = sdi;
                    if (state_q.sub == IDX_W'(reg_len(state_q.addr[1:0]) - 1)) begin
                        state_d.loaded[state_q.addr[1:0]] = 1'b1;
                        state_d.sub  = '0;
                        state_d.addr = state_q.addr + 1'b1;
                    end else begin
                        state_d.sub = state_q.sub + 1'b1;
                    end
                end
            end
            if (sck_fall) begin
                if (state_q.falls < HDR_DATA) state_d.falls = state_q.falls + 3'd1;
                if (state_q.falls == FALL_LAST && state_q.rnw) begin
                    state_d.oe     = 1'b1;
                    state_d.rd_idx = '0;
                    state_d.dout   = rd_word[0];
                end else if (state_q.oe) begin
                    if (state_q.rd_idx != '1) nxt_idx = state_q.rd_idx + 1'b1;
                    state_d.rd_idx = nxt_idx;
                    state_d.dout   = (nxt_idx < IDX_W'(WORD_W)) ? rd_word[nxt_idx] : 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign commit    = sl_rise & ~state_q.rnw;
    assign load_mask = state_q.loaded;
    assign shadow    = state_q.shadow;
    assign dout      = state_q.dout;
    assign dout_en   = state_q.oe;

    // pad is driven only in read frames
    assert_oe_read_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.oe |-> state_q.rnw);
    // strobe rising always releases the pad on the next cycle
    assert_oe_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sl_rise |=> !dout_en);
endmodule

// File: rtl/sreg_port.sv
module sreg_port import sreg_pkg::*; #(
    parameter int LOCK_CYCLES = 40000,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_load,
    input  logic        ser_clk,
    input  logic        ser_din,
    output logic        ser_dout,
    output logic        ser_dout_en,
    output logic [10:0] op_word,
    output logic [9:0]  gain_word,
    output logic [7:0]  clamp_word,
    output logic [9:0]  ctrl_word
);
    typedef struct packed {
        bank_t bank;
    } regs_t;

    regs_t           state_d, state_q;
    logic            sck_rise, sck_fall, sl_rise, sl_fall, sl_low, sdi_s;
    logic            locked, commit, commit_go;
    logic [NREG-1:0] load_mask;
    bank_t           shadow;

    sreg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sck_i(ser_clk), .sl_i(ser_load), .sdi_i(ser_din),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .sl_rise(sl_rise), .sl_fall(sl_fall), .sl_low(sl_low), .sdi_s(sdi_s)
    );

    sreg_lockout #(.CYCLES(LOCK_CYCLES)) u_lock (
        .clk(clk), .rst_n(rst_n), .locked(locked)
    );

    sreg_frame u_frame (
        .clk(clk), .rst_n(rst_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .sl_rise(sl_rise), .sl_fall(sl_fall), .sl_low(sl_low), .sdi(sdi_s),
        .rd_bank(state_q.bank),
        .commit(commit), .load_mask(load_mask), .shadow(shadow),
        .dout(ser_dout), .dout_en(ser_dout_en)
    );

    assign commit_go = commit & ~locked;

    always_comb begin
        state_d = state_q;
        if (commit_go) begin
            for (int i = 0; i < NREG; i++) begin
                if (load_mask[i]) state_d.bank[i] = shadow[i] & len_mask(i);
            end
            if (load_mask[0] && shadow[0][SWRST_BIT]) state_d.bank = bank_defaults();
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{bank: bank_defaults()};
        else        state_q <= state_d;
    end

    assign op_word    = state_q.bank[0];
    assign gain_word  = state_q.bank[1][9:0];
    assign clamp_word = state_q.bank[2][7:0];
    assign ctrl_word  = state_q.bank[3][9:0];

    // words move only on a frame-end commit
    assert_commit_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(state_q.bank));
    // lockout blocks every write
    assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(state_q.bank));
    // software reset lands on reset values
    assert_swrst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_go && load_mask[0] && shadow[0][SWRST_BIT]) |=>
        (op_word == 11'h000 && gain_word == 10'h000 &&
         clamp_word == 8'h80 && ctrl_word == 10'h000));
endmodule

// File: tb/sreg_port_test.sv
module sreg_port_test;
    localparam int LOCK = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_load = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
    logic        ser_dout, ser_dout_en;
    logic [10:0] op_word;
    logic [9:0]  gain_word;
    logic [7:0]  clamp_word;
    logic [9:0]  ctrl_word;

    int    checks = 0, errors = 0, cyc = 0;
    string cur_req = "R8";

    // model state
    logic [10:0] m_reg[4];
    logic        m_sl = 1'b1, m_sck = 1'b0, m_dout = 1'b0, m_oe = 1'b0;
    int          m_falls = 0;
    logic        bits[$];
    logic [40:0] pipe[$];

    always #2 clk = ~clk;

    sreg_port #(.LOCK_CYCLES(LOCK)) uut (
        .clk(clk), .rst_n(rst_n), .ser_load(ser_load), .ser_clk(ser_clk),
        .ser_din(ser_din), .ser_dout(ser_dout), .ser_dout_en(ser_dout_en),
        .op_word(op_word), .gain_word(gain_word), .clamp_word(clamp_word),
        .ctrl_word(ctrl_word)
    );

    function automatic int blen(input int a);
        if (a == 0) return 11;
        if (a == 2) return 8;
        return 10;
    endfunction

    function automatic void m_defaults();
        m_reg[0] = 11'h000; m_reg[1] = 11'h000; m_reg[2] = 11'h080; m_reg[3] = 11'h000;
    endfunction

    function automatic logic [40:0] snap();
        return {m_reg[0], m_reg[1][9:0], m_reg[2][7:0], m_reg[3][9:0], m_dout, m_oe};
    endfunction

    function automatic void m_commit();
        logic [10:0] nv[4];
        logic [3:0]  mk;
        logic [10:0] v;
        int a, pos;
        if (bits.size() < 5 || bits[0] !== 1'b0) return;
        if (cyc + 2 < LOCK) return;                     // R9 lockout window
        for (int i = 0; i < 4; i++) nv[i] = m_reg[i];
        mk  = '0;
        a   = int'(bits[1]) + 2 * int'(bits[2]) + 4 * int'(bits[3]);
        pos = 5;
        while (a < 4 && bits.size() >= pos + blen(a)) begin
            v = '0;
            for (int j = 0; j < blen(a); j++) v[j] = bits[pos + j];
            nv[a] = v; mk[a] = 1'b1;
            pos += blen(a);
            a++;
        end
        for (int i = 0; i < 4; i++) m_reg[i] = nv[i];
        if (mk[0] && nv[0][4]) m_defaults();
    endfunction

    function automatic void m_step(input logic sl_v, input logic sck_v, input logic sdi_v);
        int a, idx;
        if (m_sl && !sl_v) begin
            bits.delete(); m_falls = 0; m_oe = 1'b0;
        end else if (!m_sl && sl_v) begin
            m_oe = 1'b0;
            m_commit();
        end else if (!sl_v) begin
            if (!m_sck && sck_v) bits.push_back(sdi_v);
            if (m_sck && !sck_v) begin
                m_falls++;
                if (bits.size() >= 4 && bits[0] === 1'b1 && m_falls >= 5) begin
                    m_oe = 1'b1;
                    idx  = m_falls - 5;
                    a    = int'(bits[1]) + 2 * int'(bits[2]) + 4 * int'(bits[3]);
                    m_dout = (a < 4 && idx < blen(a)) ? m_reg[a][idx] : 1'b0;
                end
            end
        end
        m_sl = sl_v; m_sck = sck_v;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one system clock: compare against the model 3 cycles back, then drive
    task automatic tick(input logic sl_v, input logic sck_v, input logic sdi_v);
        logic [40:0] e;
        @(negedge clk);
        cyc++;
        e = pipe.pop_front();
        checks++;
        if ({op_word, gain_word, clamp_word, ctrl_word} !== e[40:2] ||
            ser_dout_en !== e[0] || (e[0] && ser_dout !== e[1])) begin
            errors++;
            $display("FAIL %s cycle %0d actual=%h/%b/%b expected=%h/%b/%b", cur_req, cyc,
                     {op_word, gain_word, clamp_word, ctrl_word}, ser_dout_en, ser_dout,
                     e[40:2], e[0], e[1]);
        end
        ser_load = sl_v; ser_clk = sck_v; ser_din = sdi_v;
        m_step(sl_v, sck_v, sdi_v);
        pipe.push_back(snap());
    endtask

    task automatic hold(input logic sl_v, input logic sck_v, input logic sdi_v, input int n);
        for (int i = 0; i < n; i++) tick(sl_v, sck_v, sdi_v);
    endtask

    // R1 frame: direction, address LSB first, test bit, data LSB first
    task automatic frame(input logic rnw, input int addr, input logic [63:0] data,
                         input int n, input logic [15:0] rd_exp);
        logic [63:0] seq;
        logic [15:0] cap;
        logic [2:0]  a3;
        int len;
        a3  = 3'(addr);
        seq = '0;
        seq[0] = rnw; seq[1] = a3[0]; seq[2] = a3[1]; seq[3] = a3[2]; seq[4] = 1'b0;
        for (int i = 0; i < n; i++) seq[5 + i] = data[i];
        len = 5 + n;
        cap = '0;
        hold(1'b1, 1'b0, 1'b0, 2);
        for (int i = 0; i <= len; i++) begin
            hold(1'b0, 1'b0, (i < len) ? seq[i] : 1'b0, 4);
            if (rnw && i >= 5) begin
                if (i - 5 < 16) cap[i - 5] = ser_dout;
                chk("R6", "read enable", int'(ser_dout_en), 1);
            end
            if (i < len) hold(1'b0, 1'b1, seq[i], 4);
        end
        hold(1'b1, 1'b0, 1'b0, 8);
        if (rnw) begin
            chk("R6", "read word", int'(cap), int'(rd_exp));
            chk("R6", "enable after frame", int'(ser_dout_en), 0);
        end
    endtask

    task automatic chk_words(input string req, input int op, input int gn, input int cl, input int ct);
        chk(req, "word0", int'(op_word), op);
        chk(req, "word1", int'(gain_word), gn);
        chk(req, "word2", int'(clamp_word), cl);
        chk(req, "word3", int'(ctrl_word), ct);
    endtask

    initial begin
        m_defaults();
        repeat (3) pipe.push_back(snap());
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8 reset values
        cur_req = "R8";
        hold(1'b1, 1'b0, 1'b0, 4);
        chk_words("R8", 'h000, 'h000, 'h080, 'h000);
        chk("R8", "enable idle", int'(ser_dout_en), 0);

        // R9 write during lockout is dropped
        cur_req = "R9";
        frame(1'b0, 1, 64'h155, 10, '0);
        chk("R9", "word1 locked", int'(gain_word), 'h000);
        hold(1'b1, 1'b0, 1'b0, LOCK + 20 - cyc);

        // R1 and R4 single write, words steady mid-frame (model on every clock)
        cur_req = "R4";
        frame(1'b0, 1, 64'h2A5, 10, '0);
        chk("R1", "word1 single", int'(gain_word), 'h2A5);

        // R3 continuous write across all four words
        cur_req = "R3";
        frame(1'b0, 0, {25'd0, 10'h281, 8'hC7, 10'h3FF, 11'h403}, 39, '0);
        chk_words("R3", 'h403, 'h3FF, 'hC7, 'h281);

        // R5 partial trailing word discarded
        cur_req = "R5";
        frame(1'b0, 2, {52'd0, 4'hF, 8'h3C}, 12, '0);
        chk("R5", "word2 full", int'(clamp_word), 'h3C);
        chk("R5", "word3 kept", int'(ctrl_word), 'h281);

        // R2 unmapped address
        cur_req = "R2";
        frame(1'b0, 5, 64'hFFFF, 16, '0);
        chk_words("R2", 'h403, 'h3FF, 'h3C, 'h281);

        // R10 serial clock with strobe high
        cur_req = "R10";
        for (int i = 0; i < 10; i++) begin
            hold(1'b1, 1'b1, 1'b1, 4);
            hold(1'b1, 1'b0, 1'b1, 4);
        end
        chk_words("R10", 'h403, 'h3FF, 'h3C, 'h281);
        frame(1'b0, 3, 64'h11E, 10, '0);
        chk("R10", "word3 after idle clocks", int'(ctrl_word), 'h11E);

        // R6 readback, bits past width are zero; R2 unmapped reads zero
        cur_req = "R6";
        frame(1'b1, 0, '0, 12, 16'h0403);
        frame(1'b1, 1, '0, 12, 16'h03FF);
        frame(1'b1, 2, '0, 12, 16'h003C);
        frame(1'b1, 3, '0, 12, 16'h011E);
        cur_req = "R2";
        frame(1'b1, 6, '0, 12, 16'h0000);

        // R7 software reset via word 0 bit 4
        cur_req = "R7";
        frame(1'b0, 0, 64'h015, 11, '0);
        chk_words("R7", 'h000, 'h000, 'h080, 'h000);
        cur_req = "R8";
        frame(1'b1, 2, '0, 11, 16'h0080);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule